// File: doc/BRIEF.md
# Camera Frame Crop, Halve and Decimate

This block sits at the head of a camera capture path and trims a raster pixel stream before it reaches later stages. Each incoming beat carries one pixel together with a frame-start flag and a line-start flag. Only pixels inside a programmable rectangle pass through. Each axis can optionally be reduced by two, and a rotating frame-skip mask can discard whole frames to lower the frame rate. The output is again a raster stream, with its own frame and line flags placed on the first pixel actually emitted.

Both stream edges use valid/ready. A beat moves when valid and ready are both high at a rising clock edge. The output is held in one register stage. `in_ready` is high whenever that stage is empty or is being emptied in the same cycle. While `out_valid` is high and `out_ready` is low, the output beat is frozen and no input is taken. Pixels that are discarded are still consumed at the input.

The window, the halving enables and the skip mask are plain inputs. They are captured on the input beat that carries frame-start and apply to that whole frame, so a single frame never uses two different settings.

Top module: `ccrop_top`

## Requirements
- R1: A pixel is forwarded only if its column x satisfies x0 <= x < x0+w and its row y satisfies y0 <= y < y0+h. Here x is the beat index since the last line start (0 at line start) and y is the line index since frame start (0 on the frame-start line). Every frame-start beat must also be a line-start beat.
- R2: With width halving on, only the pixels whose offset dx = x-x0 has bit 1 clear are kept (dx mod 4 in {0,1}). Whole two-pixel pairs are therefore dropped, which keeps 4:2:2 chroma aligned.
- R3: With height halving on, only the lines whose offset dy = y-y0 is even are kept.
- R4: For a crop width divisible by 4 and an even crop height, the number of output pixels per frame is the crop width times the crop height, each halved on the axes where halving is on. A 64x48 input cropped to 32x24 at origin (0,0) and halved on both axes yields 192 pixels.
- R5: A phase counter counts 0 to 5 and advances by one on every accepted frame-start beat. A frame whose start sees mask bit [phase] set is dropped entirely, including its markers. Mask 6'b101010 passes three frames out of every six.
- R6: Changes to the window, the halving enables or the mask after the frame-start beat have no effect until the next frame-start beat.
- R7: A window that reaches past the actual line or frame length is clipped to the pixels that arrive. With `out_ready` held high, `in_ready` never drops.
- R8: `out_sof` and `out_sol` are both set on the first emitted pixel of a frame. `out_sol` is set on the first emitted pixel of every later output line, and on no other beat.
- R9: While `out_valid` is high and `out_ready` is low, the output data and flags hold and `in_ready` is low. No pixel is lost or duplicated.
- R10: After reset, `out_valid` is low, `in_ready` is high and the skip phase is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_x0 | input | 12 | Window left column |
| cfg_y0 | input | 12 | Window top line |
| cfg_w | input | 12 | Window width in pixels |
| cfg_h | input | 12 | Window height in lines |
| cfg_half_x | input | 1 | Enable width halving |
| cfg_half_y | input | 1 | Enable height halving |
| cfg_skip | input | 6 | Frame drop mask, bit per phase |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high |
| in_data | input | DW | Input pixel |
| in_sof | input | 1 | Beat is first pixel of a frame |
| in_sol | input | 1 | Beat is first pixel of a line |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts output |
| out_data | output | DW | Output pixel |
| out_sof | output | 1 | First emitted pixel of a frame |
| out_sol | output | 1 | First emitted pixel of a line |

## Verification
A wrong column or line counter shifts the window, and the very next emitted pixel shows the wrong coordinate code in its data. The same holds for a wrong halving phase. A stuck or mis-stepped skip phase shows up as a missing or extra frame within one six-frame cycle. A stale shadow register shows up as a frame cut with the old window. Marker-tracking errors appear on the first emitted pixel of a frame or line. A hold error under back-pressure appears as a lost or repeated pixel at the next accepted beat.

// File: rtl/ccrop_pkg.sv
package ccrop_pkg;
  parameter int CCROP_CW = 12;
  parameter int CCROP_PHASES = 6;

  typedef struct packed {
    logic [CCROP_CW-1:0] x0;
    logic [CCROP_CW-1:0] y0;
    logic [CCROP_CW-1:0] w;
    logic [CCROP_CW-1:0] h;
    logic                half_x;
    logic                half_y;
  } ccrop_win_t;
endpackage

// File: rtl/ccrop_coord.sv
module ccrop_coord
  import ccrop_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire,
  input  logic                sof,
  input  logic                sol,
  output logic [CCROP_CW-1:0] cur_x,
  output logic [CCROP_CW-1:0] cur_y
);
  logic [CCROP_CW-1:0] x_q, y_q;
  logic line_start;

  assign line_start = sof | sol;

  always_comb begin
    cur_x = line_start ? '0 : x_q + 1'b1;
    if (sof)      cur_y = '0;
    else if (sol) cur_y = y_q + 1'b1;
    else          cur_y = y_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (fire) begin
      x_q <= cur_x;
      y_q <= cur_y;
    end
  end
endmodule

// File: rtl/ccrop_gate.sv
module ccrop_gate
  import ccrop_pkg::*;
#(
  parameter bit PAIRED = 1'b1
) (
  input  ccrop_win_t          win,
  input  logic [CCROP_CW-1:0] cur_x,
  input  logic [CCROP_CW-1:0] cur_y,
  output logic                keep
);
  logic [CCROP_CW:0]   x_end, y_end;
  logic [CCROP_CW-1:0] dx, dy;
  logic in_x, in_y, sel_x, sel_y;

  assign x_end = {1'b0, win.x0} + {1'b0, win.w};
  assign y_end = {1'b0, win.y0} + {1'b0, win.h};
  assign in_x  = (cur_x >= win.x0) && ({1'b0, cur_x} < x_end);
  assign in_y  = (cur_y >= win.y0) && ({1'b0, cur_y} < y_end);
  assign dx    = cur_x - win.x0;
  assign dy    = cur_y - win.y0;

  generate
    if (PAIRED) begin : g_pair
      assign sel_x = !win.half_x || !dx[1];
    end else begin : g_single
      assign sel_x = !win.half_x || !dx[0];
    end
  endgenerate

  assign sel_y = !win.half_y || !dy[0];
  assign keep  = in_x && in_y && sel_x && sel_y;
endmodule

// File: rtl/ccrop_skip.sv
module ccrop_skip #(
  parameter int PHASES = 6,
  localparam int PW = $clog2(PHASES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof_now,
  input  logic              sof_fire,
  input  logic [PHASES-1:0] mask,
  output logic              drop
);
  logic [PW-1:0] phase_q;
  logic          drop_q;
  logic          bit_now;

  assign bit_now = mask[phase_q];
  assign drop    = sof_now ? bit_now : drop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      drop_q  <= 1'b0;
    end else if (sof_fire) begin
      drop_q  <= bit_now;
      phase_q <= (phase_q == PW'(PHASES-1)) ? '0 : phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/ccrop_top.sv
module ccrop_top
  import ccrop_pkg::*;
#(
  parameter int DW     = 16,
  parameter bit PAIRED = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CCROP_CW-1:0]     cfg_x0,
  input  logic [CCROP_CW-1:0]     cfg_y0,
  input  logic [CCROP_CW-1:0]     cfg_w,
  input  logic [CCROP_CW-1:0]     cfg_h,
  input  logic                    cfg_half_x,
  input  logic                    cfg_half_y,
  input  logic [CCROP_PHASES-1:0] cfg_skip,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [DW-1:0]           in_data,
  input  logic                    in_sof,
  input  logic                    in_sol,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [DW-1:0]           out_data,
  output logic                    out_sof,
  output logic                    out_sol
);
  ccrop_win_t win_in, win_sh, win_eff;
  logic fire, keep, drop, emit;
  logic sof_pend_q, sol_pend_q, sof_mark, sol_mark;
  logic [CCROP_CW-1:0] cur_x, cur_y;

  assign win_in = '{x0: cfg_x0, y0: cfg_y0, w: cfg_w, h: cfg_h,
                    half_x: cfg_half_x, half_y: cfg_half_y};
  assign win_eff  = in_sof ? win_in : win_sh;
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  ccrop_coord u_coord (
    .clk(clk), .rst_n(rst_n), .fire(fire), .sof(in_sof), .sol(in_sol),
    .cur_x(cur_x), .cur_y(cur_y)
  );

  ccrop_gate #(.PAIRED(PAIRED)) u_gate (
    .win(win_eff), .cur_x(cur_x), .cur_y(cur_y), .keep(keep)
  );

  ccrop_skip #(.PHASES(CCROP_PHASES)) u_skip (
    .clk(clk), .rst_n(rst_n), .sof_now(in_sof), .sof_fire(fire && in_sof),
    .mask(cfg_skip), .drop(drop)
  );

  assign emit     = keep && !drop;
  assign sof_mark = in_sof || sof_pend_q;
  assign sol_mark = in_sof || in_sol || sol_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_sh     <= '0;
      sof_pend_q <= 1'b0;
      sol_pend_q <= 1'b0;
    end else if (fire) begin
      if (in_sof) win_sh <= win_in;
      sof_pend_q <= sof_mark && !emit;
      sol_pend_q <= sol_mark && !emit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_sol   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= fire && emit;
      if (fire && emit) begin
        out_data <= in_data;
        out_sof  <= sof_mark;
        out_sol  <= sol_mark;
      end
    end
  end
endmodule

// File: rtl/ccrop_chk.sv
module ccrop_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_sof,
  input logic          out_sol
);
  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_sol)); // R9
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R9
  AST_SOF_HAS_SOL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sof |-> out_sol); // R8
  AST_EMIT_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready)); // R1
endmodule

bind ccrop_top ccrop_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_sof(out_sof), .out_sol(out_sol)
);

// File: tb/sim_ccrop_top.sv
`timescale 1ns/1ps
module sim_ccrop_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] cfg_x0 = '0, cfg_y0 = '0, cfg_w = '0, cfg_h = '0;
  logic cfg_half_x = 1'b0, cfg_half_y = 1'b0;
  logic [5:0] cfg_skip = '0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0;
  logic [15:0] in_data = '0;
  logic in_ready, out_valid, out_sof, out_sol;
  logic out_ready = 1'b1;
  logic [15:0] out_data;

  ccrop_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_x0(cfg_x0), .cfg_y0(cfg_y0), .cfg_w(cfg_w),
    .cfg_h(cfg_h), .cfg_half_x(cfg_half_x), .cfg_half_y(cfg_half_y),
    .cfg_skip(cfg_skip), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_sol(in_sol), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof), .out_sol(out_sol)
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, stalls = 0, out_cnt = 0, sof_cnt = 0;
  int ph = 0;
  bit bp = 1'b0;
  string req = "R1";
  logic [17:0] exp_q[$];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 out_ready = bp ? (cyc % 3 != 0) : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      total++;
      out_cnt++;
      if (out_sof) sof_cnt++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL %s: unexpected beat %h sof=%0b sol=%0b, expected none", req, out_data, out_sof, out_sol);
      end else begin
        logic [17:0] e;
        e = exp_q.pop_front();
        if ({out_sof, out_sol, out_data} !== e) begin
          bad++;
          $display("FAIL %s: got sof=%0b sol=%0b data=%h expected sof=%0b sol=%0b data=%h",
                   req, out_sof, out_sol, out_data, e[17], e[16], e[15:0]);
        end
      end
    end
  end

  initial begin
    #600000;
    bad++; total++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input string r, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", r, act, expv);
    end
  endtask

  // reference model of one frame, following R1 R2 R3 R5 R8
  task automatic model_frame(input int iw, input int ih);
    bit drop, fs, ls;
    drop = cfg_skip[ph];
    ph = (ph + 1) % 6;
    if (drop) return;
    fs = 1'b1;
    for (int y = 0; y < ih; y++) begin
      ls = 1'b1;
      for (int x = 0; x < iw; x++) begin
        int dx, dy;
        dx = x - int'(cfg_x0);
        dy = y - int'(cfg_y0);
        if (dx >= 0 && dx < int'(cfg_w) && dy >= 0 && dy < int'(cfg_h) &&
            (!cfg_half_x || ((dx / 2) % 2 == 0)) && (!cfg_half_y || (dy % 2 == 0))) begin
          exp_q.push_back({fs, ls, y[7:0], x[7:0]});
          fs = 1'b0;
          ls = 1'b0;
        end
      end
    end
  endtask

  task automatic push(input logic [15:0] d, input bit s, input bit l);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sof = s; in_sol = l;
    while (!in_ready) begin stalls++; @(negedge clk); end
  endtask

  task automatic drive_frame(input int iw, input int ih, input bit mid);
    logic [11:0] sx0, sw;
    logic [5:0] sk;
    logic shx;
    model_frame(iw, ih);
    sx0 = cfg_x0; sw = cfg_w; sk = cfg_skip; shx = cfg_half_x;
    for (int y = 0; y < ih; y++)
      for (int x = 0; x < iw; x++) begin
        push({y[7:0], x[7:0]}, (x == 0 && y == 0), (x == 0));
        if (mid && x == 1 && y == 0) begin
          cfg_x0 = 12'd0; cfg_w = 12'd1; cfg_half_x = ~shx; cfg_skip = 6'h3f;
        end
      end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_sol = 1'b0;
    if (mid) begin cfg_x0 = sx0; cfg_w = sw; cfg_skip = sk; cfg_half_x = shx; end
  endtask

  task automatic drain(input string r);
    repeat (12) @(negedge clk);
    check(r, exp_q.size(), 0);
  endtask

  task automatic set_cfg(input int x0, input int y0, input int w, input int h,
                         input bit hx, input bit hy, input logic [5:0] sk);
    cfg_x0 = x0[11:0]; cfg_y0 = y0[11:0]; cfg_w = w[11:0]; cfg_h = h[11:0];
    cfg_half_x = hx; cfg_half_y = hy; cfg_skip = sk;
  endtask

  task automatic t_reset;
    req = "R10";
    @(negedge clk);
    check("R10 out_valid", int'(out_valid), 0);
    check("R10 in_ready", int'(in_ready), 1);
  endtask

  task automatic t_crop;
    req = "R1";
    set_cfg(3, 2, 8, 5, 0, 0, 6'h00);
    out_cnt = 0;
    drive_frame(20, 10, 0);
    drain("R1 leftover");
    check("R1 count", out_cnt, 40);
    req = "R8";
    set_cfg(0, 0, 20, 3, 0, 0, 6'h00);
    drive_frame(6, 4, 0);
    drain("R8 leftover");
  endtask

  task automatic t_halve_x;
    req = "R2";
    set_cfg(1, 0, 12, 2, 1, 0, 6'h00);
    out_cnt = 0;
    drive_frame(16, 3, 0);
    drain("R2 leftover");
    check("R2 count", out_cnt, 12);
  endtask

  task automatic t_halve_y;
    req = "R3";
    set_cfg(0, 1, 4, 5, 0, 1, 6'h00);
    out_cnt = 0;
    drive_frame(6, 8, 0);
    drain("R3 leftover");
    check("R3 count", out_cnt, 12);
  endtask

  task automatic t_dims;
    req = "R4";
    set_cfg(0, 0, 32, 24, 1, 1, 6'h00);
    out_cnt = 0;
    drive_frame(64, 48, 0);
    drain("R4 leftover");
    check("R4 pixels per frame", out_cnt, 192);
  endtask

  task automatic t_skip;
    req = "R5";
    set_cfg(0, 0, 8, 4, 0, 0, 6'b101010);
    sof_cnt = 0;
    for (int f = 0; f < 6; f++) drive_frame(8, 4, 0);
    drain("R5 leftover");
    check("R5 frames out of six", sof_cnt, 3);
  endtask

  task automatic t_shadow;
    req = "R6";
    set_cfg(2, 0, 4, 3, 0, 0, 6'h00);
    out_cnt = 0;
    drive_frame(8, 3, 1);
    drain("R6 leftover");
    check("R6 count", out_cnt, 12);
  endtask

  task automatic t_clip;
    req = "R7";
    set_cfg(5, 2, 100, 100, 0, 0, 6'h00);
    out_cnt = 0; stalls = 0;
    drive_frame(16, 6, 0);
    drain("R7 leftover");
    check("R7 count", out_cnt, 44);
    check("R7 stalls", stalls, 0);
    drive_frame(10, 4, 0);
    drain("R7 next frame");
  endtask

  task automatic t_bp;
    req = "R9";
    bp = 1'b1;
    set_cfg(1, 1, 12, 6, 1, 1, 6'h00);
    out_cnt = 0;
    drive_frame(14, 8, 0);
    drive_frame(14, 8, 0);
    repeat (40) @(negedge clk);
    bp = 1'b0;
    drain("R9 leftover");
    check("R9 count", out_cnt, 36);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_crop();
    t_halve_x();
    t_halve_y();
    t_dims();
    t_skip();
    t_shadow();
    t_clip();
    t_bp();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule